// File: doc/BRIEF.md
# Serial Configuration Batch Loader

This block takes a configuration image from a host over a two-wire clocked serial link, a serial clock and a serial data line, after reset. The host sends nine 32-bit words: a parameter word first, then eight address words for the slots A to H. The block samples the data line on every falling edge of the serial clock, builds each word MSB first, and writes it into a nine-entry register file. Each write is also shown for one cycle on a strobe with its word index. A done flag rises once the ninth word is stored.

The serial clock and data are brought into the system clock domain through a synchronizer chain. Falling edges are detected there. A gap timer counts system clocks since the last falling edge. If the serial clock drops below its minimum rate, the timer clears the bit counter, so a stray or interrupted transfer cannot leave later words misaligned. Words already stored are kept. A neighbouring block reads the stored words through a combinational select port.

Top module: `cfg_batch_loader`

## Requirements
- R1: The data line is sampled on each falling edge of the serial clock, and a word is assembled MSB first: the first bit sampled becomes bit 31.
- R2: Every 32nd sampled bit completes a word, and the block then asserts `wr_valid` for exactly one system clock, with the word on `wr_data` and its index on `wr_idx`.
- R3: Word indices run in arrival order: index 0 is the parameter word and indices 1 to 8 are address slots A to H. Word k of a load is stored at entry k, and `rd_word` shows entry `rd_sel`.
- R4: `load_done` rises on the cycle after the strobe for index 8, and it stays high until reset.
- R5: Once `load_done` is high, further serial clock edges have no effect: there is no strobe and the stored words do not change.
- R6: If more than GAP_LIMIT = CLK_HZ/MIN_SCK_HZ system clocks pass without a falling edge, the bit counter returns to zero and the partial word is discarded. The word index is kept, so the next complete word goes to the same entry.
- R7: Gaps between falling edges of GAP_LIMIT clocks or fewer keep the partial word intact.
- R8: A synchronous active-high reset clears the bit counter, the word index, `load_done` and every stored word. After reset, `rd_word` reads zero and the next word goes to index 0.
- R9: A value of `rd_sel` of 9 or more reads zero on `rd_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Host serial clock; idles high |
| ser_dat | input | 1 | Host serial data, sampled on the falling edge of ser_clk |
| wr_valid | output | 1 | One-cycle strobe when a word completes |
| wr_idx | output | 4 | Index of the word being written |
| wr_data | output | 32 | Completed word |
| load_done | output | 1 | All nine words stored |
| rd_sel | input | 4 | Register file read select |
| rd_word | output | 32 | Stored word at rd_sel |

## Verification
The checker assumes that each phase of the serial clock lasts at least a few system clocks, so that detected falling edges are always several cycles apart. It also assumes that the data line is stable across each falling edge. The bench holds each phase for 20 system clocks and changes data only while the serial clock is high. For timeout cases it stretches a high phase to just below the limit, or idles well beyond it.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 9;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int BIT_W     = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BIT_W-1:0]  bitcnt_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } word_evt_t;

    function automatic int gap_cycles(input int clk_hz, input int min_hz);
        return clk_hz / min_hz;
    endfunction
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic sdi_in,
    output logic sck_fall,
    output logic sdi_s
);
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] sdi_q;
    logic              sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= '1;
            sdi_q    <= '0;
            sck_prev <= 1'b1;
        end else begin
            sck_q    <= {sck_q[STAGES-2:0], sck_in};
            sdi_q    <= {sdi_q[STAGES-2:0], sdi_in};
            sck_prev <= sck_q[STAGES-1];
        end
    end

    assign sck_fall = sck_prev & ~sck_q[STAGES-1];
    assign sdi_s    = sdi_q[STAGES-1];
endmodule

// File: rtl/sck_gap_timer.sv
module sck_gap_timer #(
    parameter int LIMIT = 41666
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_seen,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst || edge_seen)
            gap_cnt <= '0;
        else if (gap_cnt != CW'(LIMIT))
            gap_cnt <= gap_cnt + 1'b1;
    end

    assign timeout = !edge_seen && (gap_cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import cfg_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      bit_strobe,
    input  logic      bit_in,
    input  logic      flush,
    output bitcnt_t   bit_cnt,
    output word_evt_t evt
);
    word_t shreg;
    word_t next_word;

    assign next_word = {shreg[WORD_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            evt     <= '0;
        end else begin
            evt.valid <= 1'b0;
            if (enable && bit_strobe) begin
                shreg <= next_word;
                if (bit_cnt == bitcnt_t'(WORD_W - 1)) begin
                    bit_cnt   <= '0;
                    evt.valid <= 1'b1;
                    evt.data  <= next_word;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (flush) begin
                bit_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/batch_store.sv
module batch_store
    import cfg_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_evt_t evt,
    output idx_t      cur_idx,
    output logic      done,
    input  idx_t      rd_sel,
    output word_t     rd_word
);
    word_t mem [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= '0;
            done    <= 1'b0;
        end else if (evt.valid && !done) begin
            if (cur_idx == idx_t'(NUM_WORDS - 1))
                done <= 1'b1;
            else
                cur_idx <= cur_idx + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (evt.valid && !done && cur_idx == idx_t'(g))
                mem[g] <= evt.data;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++)
            if (rd_sel == idx_t'(i))
                rd_word = mem[i];
    end
endmodule

// File: rtl/cfg_batch_loader.sv
module cfg_batch_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int MIN_SCK_HZ  = 1200,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_dat,
    output logic        wr_valid,
    output logic [3:0]  wr_idx,
    output logic [31:0] wr_data,
    output logic        load_done,
    input  logic [3:0]  rd_sel,
    output logic [31:0] rd_word
);
    localparam int GAP_LIMIT = gap_cycles(CLK_HZ, MIN_SCK_HZ);

    logic      sck_fall;
    logic      sdi_s;
    logic      gap_timeout;
    bitcnt_t   bit_cnt;
    word_evt_t evt;
    idx_t      cur_idx;

    ser_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .sck_in(ser_clk), .sdi_in(ser_dat),
        .sck_fall(sck_fall), .sdi_s(sdi_s)
    );

    sck_gap_timer #(.LIMIT(GAP_LIMIT)) gap_i (
        .clk(clk), .rst(rst), .edge_seen(sck_fall), .timeout(gap_timeout)
    );

    word_shifter shift_i (
        .clk(clk), .rst(rst), .enable(!load_done), .bit_strobe(sck_fall),
        .bit_in(sdi_s), .flush(gap_timeout), .bit_cnt(bit_cnt), .evt(evt)
    );

    batch_store store_i (
        .clk(clk), .rst(rst), .evt(evt), .cur_idx(cur_idx), .done(load_done),
        .rd_sel(rd_sel), .rd_word(rd_word)
    );

    assign wr_valid = evt.valid;
    assign wr_data  = evt.data;
    assign wr_idx   = cur_idx;
endmodule

// File: rtl/cfg_batch_loader_chk.sv
module cfg_batch_loader_chk
    import cfg_loader_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    wr_valid,
    input idx_t    wr_idx,
    input logic    load_done,
    input logic    timeout,
    input bitcnt_t bit_cnt
);
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_idx <= idx_t'(NUM_WORDS - 1)));

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        load_done |=> load_done);

    assert_done_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(load_done) |-> ($past(wr_valid) && $past(wr_idx) == idx_t'(NUM_WORDS - 1)));

    assert_quiet_after_done_R5: assert property (@(posedge clk) disable iff (rst)
        load_done |-> !wr_valid);

    assert_timeout_clears_R6: assert property (@(posedge clk) disable iff (rst)
        timeout |=> (bit_cnt == '0));
endmodule

bind cfg_batch_loader cfg_batch_loader_chk chk_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .load_done(load_done), .timeout(gap_timeout), .bit_cnt(bit_cnt)
);

// File: tb/cfg_batch_loader_tb_top.sv
module cfg_batch_loader_tb_top;
    localparam int HALF  = 20;
    localparam int LIMIT = 200;

    typedef struct {
        int          idx;
        logic [31:0] data;
        string       req;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        ser_clk = 1;
    logic        ser_dat = 0;
    logic        wr_valid;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic        load_done;
    logic [3:0]  rd_sel = 0;
    logic [31:0] rd_word;

    int n_tests = 0;
    int n_fail  = 0;
    exp_t sb_q[$];
    logic [31:0] exp_mem [9];
    int exp_idx = 0;

    always #10 clk = ~clk;

    cfg_batch_loader #(.CLK_HZ(LIMIT * 1200)) dut_i (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
        .load_done(load_done), .rd_sel(rd_sel), .rd_word(rd_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare each strobe against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && wr_valid) begin
            if (sb_q.size() == 0) begin
                check("R5 unexpected strobe", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " wr_data"}, wr_data, e.data);
                check({e.req, " wr_idx"}, {28'h0, wr_idx}, e.idx);
            end
        end
    end

    task automatic send_bits(input logic [31:0] w, input int nbits, input int pause_at, input int pause_len);
        for (int b = 31; b > 31 - nbits; b--) begin
            @(negedge clk);
            ser_clk = 1;
            ser_dat = w[b];
            repeat (HALF) @(negedge clk);
            if (31 - b == pause_at) repeat (pause_len) @(negedge clk);
            ser_clk = 0;
            repeat (HALF) @(negedge clk);
        end
        ser_clk = 1;
    endtask

    // driver: push expectation then shift the word out
    task automatic send_word(input logic [31:0] w, input string req, input int pause_at = -1, input int pause_len = 0);
        exp_t e;
        e.idx = exp_idx; e.data = w; e.req = req;
        sb_q.push_back(e);
        exp_mem[exp_idx] = w;
        exp_idx++;
        send_bits(w, 32, pause_at, pause_len);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        ser_clk = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        exp_idx = 0;
        for (int i = 0; i < 9; i++) exp_mem[i] = '0;
    endtask

    task automatic check_mem(input string req);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            rd_sel = 4'(i);
            #1;
            check(req, rd_word, exp_mem[i]);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5C3_0F81 ^ (32'h1357_9BDF * i) ^ {i[7:0], 24'h0};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R8 done after reset", {31'h0, load_done}, 32'h0);
        check("R8 strobe after reset", {31'h0, wr_valid}, 32'h0);
        check_mem("R8 cleared storage");

        // stray partial transfer, then a long idle: must be discarded (R6)
        send_bits(32'hFFFF_FFFF, 13, -1, 0);
        repeat (LIMIT + 100) @(negedge clk);

        // full load; word 2 has a gap just under the limit (R7), MSB-first patterns (R1)
        send_word(32'h8000_0001, "R1 param word");
        send_word(32'h0123_4567, "R3 slot A");
        send_word(pat(2), "R7 gap under limit", 10, LIMIT - 2 * HALF - 10);
        for (int i = 3; i < 9; i++) send_word(pat(i), "R2 address word");
        repeat (10) @(negedge clk);
        check("R4 done after ninth", {31'h0, load_done}, 32'h1);
        check_mem("R3 stored words");

        // extra traffic after done is ignored (R5)
        send_bits(32'hDEAD_BEEF, 32, -1, 0);
        repeat (10) @(negedge clk);
        check("R5 done held", {31'h0, load_done}, 32'h1);
        check_mem("R5 storage unchanged");

        // out-of-range reads (R9)
        for (int s = 9; s < 16; s++) begin
            @(negedge clk);
            rd_sel = 4'(s);
            #1;
            check("R9 out of range read", rd_word, 32'h0);
        end

        // timeout mid-load keeps completed words (R6)
        do_reset();
        for (int i = 0; i < 3; i++) send_word(~pat(i), "R6 before timeout");
        send_bits(32'h5555_5555, 20, -1, 0);
        repeat (LIMIT + 100) @(negedge clk);
        check("R6 not done", {31'h0, load_done}, 32'h0);
        for (int i = 3; i < 9; i++) send_word(~pat(i) ^ 32'hF0F0_0F0F, "R6 after timeout");
        repeat (10) @(negedge clk);
        check("R6 done", {31'h0, load_done}, 32'h1);
        check_mem("R6 storage after retry");

        // reset mid-load restarts index (R8)
        do_reset();
        send_word(32'hCAFE_0001, "R8 pre-reset");
        send_word(32'hCAFE_0002, "R8 pre-reset");
        repeat (10) @(negedge clk);
        do_reset();
        check_mem("R8 cleared mid-load");
        send_word(32'h1234_ABCD, "R8 index restart");
        repeat (10) @(negedge clk);
        check("R8 done after restart", {31'h0, load_done}, 32'h0);
        check_mem("R8 first slot after restart");

        repeat (10) @(negedge clk);
        check("R2 scoreboard drained", sb_q.size(), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule